// File: doc/BRIEF.md
# Burst Address Generator

This block turns one burst command into the sequence of per-beat byte addresses that a bus manager presents. A command carries a start address, a 3-bit size code and a burst type. The beat size in bytes is 2 raised to the size code. Incrementing bursts step by the beat size on every beat. Wrapping bursts stay inside an aligned block whose size is the beat count times the beat size. The step and the block are both worked out from the size code when the command arrives, so one instance serves every beat width up to the data bus width given by a parameter.

The command enters on a valid/ready channel. `cmd_ready` is high only while no burst is in progress. The beats leave on a second valid/ready channel. A beat is consumed on a clock edge where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the current beat and its flags are held unchanged, so the consumer may stall for any number of cycles. Each burst reports its total byte footprint. An illegal command is rejected with a one-cycle error pulse and produces no beats.

Top module: `burst_addr_gen`

## Requirements
- R1: The beat size is 2^size bytes. For an incrementing burst (type codes 1, 3, 5, 7), beat n carries start + n×2^size, modulo 2^ADDR_W.
- R2: For a wrapping burst (type codes 2, 4, 6, with 4, 8 and 16 beats), let B = beats×2^size. Beat n carries (start & ~(B-1)) | ((start + n×2^size) & (B-1)).
- R3: Type 0 issues exactly 1 beat. Types 2 and 3 issue exactly 4 beats, types 4 and 5 exactly 8, and types 6 and 7 exactly 16. `beat_last` is high on the final beat of these bursts and low on every other beat.
- R4: Type 1 is open-ended, and `beat_last` is never high for it. It ends on the first consumed beat that has `beat_stop` high. `beat_stop` has no effect on fixed-length bursts, and no effect on a cycle where the beat is not consumed.
- R5: `footprint` is loaded when a legal command is accepted and holds until the next accepted command. Its value is beats×2^size for fixed-length types and 0 for type 1.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_addr` and `beat_last` stay stable and `beat_valid` stays high.
- R7: A command whose beat size exceeds BUS_BYTES is rejected. `cfg_err` is high for exactly the one cycle after acceptance, and no beat is issued.
- R8: A command whose start address is not a multiple of the beat size is rejected in the same way as in R7.
- R9: After reset, `beat_valid` is 0, `cmd_ready` is 1, `cfg_err` is 0 and `footprint` is 0.
- R10: `cmd_ready` is low for the whole time a burst is in progress. It is high again in the cycle after the final beat is consumed, and `beat_valid` is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command taken this edge |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | 3 | Size code, beat = 2^code bytes |
| cmd_burst | input | 3 | Burst type code (see R1 to R4) |
| beat_valid | output | 1 | Beat address presented |
| beat_ready | input | 1 | Consumer takes the beat this edge |
| beat_addr | output | ADDR_W | Current beat byte address |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| beat_stop | input | 1 | Ends an open-ended burst on a consumed beat |
| footprint | output | FOOT_W | Total bytes of the accepted burst |
| cfg_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
Two functions can act on the same edge: the consumer's stall or acceptance of a beat, and the `beat_stop` request. The bench drives `beat_stop` with a free-running pseudo-random bit during fixed-length bursts. During open-ended bursts it holds `beat_stop` high on the chosen beat while `beat_ready` is stalled in a fixed pattern or a pseudo-random one. An early end, a missing end, a skipped address or a repeated address therefore shows up as a wrong beat count or a wrong `beat_addr`. The expected values are computed arithmetically in the bench. The sweep covers every size code, every burst type, aligned and misaligned starts, and a start near the top of the address space.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [2:0] {
    BT_ONE    = 3'd0,
    BT_OPEN   = 3'd1,
    BT_WRAP4  = 3'd2,
    BT_STEP4  = 3'd3,
    BT_WRAP8  = 3'd4,
    BT_STEP8  = 3'd5,
    BT_WRAP16 = 3'd6,
    BT_STEP16 = 3'd7
  } burst_e;

  // log2 of the beat count; 0 for single and open-ended
  function automatic logic [2:0] beats_lg(input logic [2:0] code);
    case (code)
      3'd2, 3'd3: beats_lg = 3'd2;
      3'd4, 3'd5: beats_lg = 3'd3;
      3'd6, 3'd7: beats_lg = 3'd4;
      default:    beats_lg = 3'd0;
    endcase
  endfunction

  function automatic logic is_wrap(input logic [2:0] code);
    is_wrap = (code == BT_WRAP4) || (code == BT_WRAP8) || (code == BT_WRAP16);
  endfunction

  function automatic logic is_open(input logic [2:0] code);
    is_open = (code == BT_OPEN);
  endfunction
endpackage

// File: rtl/bag_size_check.sv
module bag_size_check #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4
) (
  input  logic [2:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] step,
  output logic              size_ok,
  output logic              align_ok
);
  localparam int BUS_LG = $clog2(BUS_BYTES);

  always_comb begin
    step     = ADDR_W'(1) << size;
    size_ok  = (int'(size) <= BUS_LG);
    align_ok = ((addr & (step - ADDR_W'(1))) == '0);
  end
endmodule

// File: rtl/bag_addr_step.sv
module bag_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] step,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] blk_mask,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = cur + step;
    if (wrap) nxt = (cur & ~blk_mask) | (sum & blk_mask);
    else      nxt = sum;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] len_lg_in,
  input  logic       open_in,
  input  logic       adv,
  output logic       last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      open_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      lim_q  <= CNT_W'((1 << len_lg_in) - 1);
      open_q <= open_in;
    end else if (adv && !last && !open_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign last = !open_q && (cnt_q == lim_q);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter  int ADDR_W    = 32,
  parameter  int BUS_BYTES = 4,
  localparam int FOOT_W    = $clog2(BUS_BYTES) + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_size,
  input  logic [2:0]        cmd_burst,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  input  logic              beat_stop,
  output logic [FOOT_W-1:0] footprint,
  output logic              cfg_err
);
  import bag_pkg::*;

  logic              busy_q, wrap_q, open_q, err_q;
  logic [ADDR_W-1:0] cur_q, step_q, mask_q, nxt;
  logic [FOOT_W-1:0] foot_q;
  logic [ADDR_W-1:0] cmd_step;
  logic              size_ok, align_ok, accept, legal, adv, done, last;
  logic [2:0]        len_lg;
  logic [3:0]        span_lg;

  bag_size_check #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
    .size(cmd_size), .addr(cmd_addr), .step(cmd_step),
    .size_ok(size_ok), .align_ok(align_ok)
  );

  bag_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur(cur_q), .step(step_q), .wrap(wrap_q), .blk_mask(mask_q), .nxt(nxt)
  );

  always_comb begin
    accept  = cmd_valid && !busy_q;
    legal   = size_ok && align_ok;
    len_lg  = beats_lg(cmd_burst);
    span_lg = {1'b0, len_lg} + {1'b0, cmd_size};
    adv     = busy_q && beat_ready;
    done    = adv && (last || (open_q && beat_stop));
  end

  bag_beat_ctr #(.CNT_W(4)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(accept && legal),
    .len_lg_in(len_lg), .open_in(is_open(cmd_burst)),
    .adv(adv), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wrap_q <= 1'b0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
      cur_q  <= '0;
      step_q <= '0;
      mask_q <= '0;
      foot_q <= '0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) begin
        busy_q <= 1'b1;
        cur_q  <= cmd_addr;
        step_q <= cmd_step;
        wrap_q <= is_wrap(cmd_burst);
        open_q <= is_open(cmd_burst);
        mask_q <= is_wrap(cmd_burst) ? (ADDR_W'(1) << span_lg) - ADDR_W'(1) : '0;
        foot_q <= is_open(cmd_burst) ? '0 : FOOT_W'(1) << span_lg;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (adv) begin
        cur_q <= nxt;
      end
    end
  end

  assign cmd_ready  = !busy_q;
  assign beat_valid = busy_q;
  assign beat_addr  = cur_q;
  assign beat_last  = busy_q && last;
  assign footprint  = foot_q;
  assign cfg_err    = err_q;

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_last)));

  // R1
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !done && !wrap_q) |=> (beat_addr == $past(beat_addr) + $past(step_q)));

  // R2
  wrap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !done && wrap_q) |=> (((beat_addr ^ $past(beat_addr)) & ~mask_q) == '0));

  // R4
  open_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && open_q) |-> !beat_last);

  // R7
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_valid);

  // R10
  free_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (cmd_ready && !beat_valid));

  // R5
  foot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> $stable(footprint));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 16;
  localparam int BB = 8;
  localparam int FW = $clog2(BB) + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, beat_valid, beat_ready, beat_last, beat_stop, cfg_err;
  logic [AW-1:0] cmd_addr, beat_addr;
  logic [2:0]    cmd_size, cmd_burst;
  logic [FW-1:0] footprint;
  int            vecs = 0;
  int            errs = 0;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BUS_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_last(beat_last), .beat_stop(beat_stop), .footprint(footprint),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input int start, input int size, input int burst,
                           input int rp, input int stopk);
    int s, nb, n, guard, blk, ea, foot;
    bit wrap, open, legal, done, rdy, stp, stalled;
    s     = 1 << size;
    open  = (burst == 1);
    wrap  = (burst == 2) || (burst == 4) || (burst == 6);
    nb    = (burst == 0 || burst == 1) ? 1 : (burst < 4 ? 4 : (burst < 6 ? 8 : 16));
    legal = (s <= BB) && ((start % s) == 0);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = AW'(start); cmd_size = 3'(size); cmd_burst = 3'(burst);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    if (!legal) begin
      chk(cfg_err == 1'b1, (s > BB) ? "R7" : "R8", "cfg_err pulse", cfg_err, 1);
      chk(beat_valid == 1'b0, (s > BB) ? "R7" : "R8", "no beat", beat_valid, 0);
      @(posedge clk); @(negedge clk);
      chk(cfg_err == 1'b0, "R7", "cfg_err one cycle", cfg_err, 0);
      chk(beat_valid == 1'b0, "R8", "still no beat", beat_valid, 0);
      return;
    end
    foot = open ? 0 : nb * s;
    chk(cfg_err == 1'b0, "R7", "no error on legal", cfg_err, 0);
    chk(footprint == FW'(foot), "R5", "footprint", footprint, foot);
    blk = nb * s; n = 0; guard = 0; done = 0; stalled = 0;
    while (!done && guard < 200) begin
      guard++;
      chk(beat_valid == 1'b1, "R3", "beat_valid in burst", beat_valid, 1);
      chk(cmd_ready == 1'b0, "R10", "busy cmd_ready", cmd_ready, 0);
      if (wrap) ea = (start & ~(blk - 1)) | ((start + n * s) & (blk - 1));
      else      ea = (start + n * s) & ((1 << AW) - 1);
      chk(beat_addr == AW'(ea), stalled ? "R6" : (wrap ? "R2" : "R1"), "beat_addr", beat_addr, ea);
      chk(beat_last == (!open && n == nb - 1), open ? "R4" : "R3", "beat_last",
          beat_last, (!open && n == nb - 1));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = (rp == 0) ? 1'b1 : ((rp == 1) ? guard[0] : lfsr[0]);
      stp = open ? (n == stopk) : lfsr[1];
      beat_ready = rdy; beat_stop = stp;
      @(posedge clk); @(negedge clk);
      stalled = !rdy;
      if (rdy) begin
        if ((!open && n == nb - 1) || (open && stp)) done = 1;
        n++;
      end
    end
    beat_ready = 1'b0; beat_stop = 1'b0;
    chk(n == (open ? stopk + 1 : nb), open ? "R4" : "R3", "beat count", n, open ? stopk + 1 : nb);
    chk(beat_valid == 1'b0, "R10", "idle after last", beat_valid, 0);
    chk(cmd_ready == 1'b1, "R10", "ready after last", cmd_ready, 1);
    chk(footprint == FW'(foot), "R5", "footprint held", footprint, foot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int st;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_size = '0; cmd_burst = '0;
    beat_ready = 1'b0; beat_stop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(beat_valid == 1'b0, "R9", "reset beat_valid", beat_valid, 0);
    chk(cmd_ready == 1'b1, "R9", "reset cmd_ready", cmd_ready, 1);
    chk(cfg_err == 1'b0, "R9", "reset cfg_err", cfg_err, 0);
    chk(footprint == '0, "R9", "reset footprint", footprint, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sz = 0; sz < 8; sz++)
      for (int bt = 0; bt < 8; bt++)
        for (int si = 0; si < 4; si++)
          for (int rp = 0; rp < 3; rp++) begin
            case (si)
              0: st = 0;
              1: st = 16'h0038 & ~((1 << sz) - 1);
              2: st = 16'hFFF0 & ~((1 << sz) - 1);
              default: st = (sz == 0) ? 16'h0005 : (16'h0040 | ((1 << sz) >> 1));
            endcase
            run_burst(st, sz, bt, rp, (si + sz + rp) % 5);
          end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule